// File: doc/BRIEF.md
# FPU Context Frame Save/Restore Sequencer

This block carries out the two context-switch operations of a coprocessor-style floating-point unit over a 32-bit word memory port. For a save, it writes a fixed frame that describes an idle unit. For a restore, it reads one frame header and works out the address just past the frame. Each operation takes a start address, an addressing mode and a core-generation select. The generation select picks between the older coprocessor frame set and the integrated-core frame set.

The engine returns the updated address-register value when the mode is postincrement or predecrement. The two register-direct modes are rejected at once as illegal and produce no memory traffic. Every memory access uses a valid/ready handshake. When an operation finishes, the engine raises a done pulse for one cycle, and the result flags and the write-back address are valid in that same cycle.

Encodings:
- `op_restore_i`: 0 selects save, 1 selects restore.
- `gen_i`: 0 selects the older core, 1 selects the integrated core.
- `mode_i`: 0 is address-register indirect, 1 is postincrement, 2 is predecrement, 3 is register-direct.
- Frame header: bits 31:24 hold the frame version byte, and bits 23:16 hold the size/format byte.

Top module: `fpu_ctx_frame_engine`

## Requirements
- R1: A save for the older core (gen 0) in indirect or postincrement mode writes seven words upward from the start address A, one word at each of A, A+4, …, A+24. The word values, in address order, are 0x1F180000, then five words of 0x00000000, then 0x70000000. In postincrement mode the write-back address is A+28.
- R2: A save for the integrated core (gen 1) writes the single word 0x41000000.
- R3: A save in predecrement mode writes from the top downward. The first write is at A-4 and carries the highest-address word of the frame. Each following write is 4 lower, so the header ends up at the lowest address. The write-back address is A minus 4 times the word count (A-28 for gen 0, A-4 for gen 1).
- R4: In indirect mode (mode 0), `wb_en_o` stays 0 in the done cycle, for both save and restore.
- R5: On restore, a header whose bits 31:24 are zero is a null frame. Only the 4-byte header is consumed, whatever bits 23:16 hold, and no format error is raised.
- R6: On an older-core restore with a non-null header, a size byte (bits 23:16) of 0x18 adds 24 bytes beyond the header, 0x38 adds 56 bytes, and 0xB4 adds 180 bytes.
- R7: On an integrated-core restore with a non-null header, a format byte (bits 23:16) of 0x00 adds 0 bytes, 0x30 adds 44 bytes, and 0x60 adds 92 bytes.
- R8: A restore issues exactly one read.
  - In predecrement mode, the read is at A-4 and the write-back address is A-4-size.
  - In postincrement and indirect modes, the read is at A.
  - In postincrement mode, the write-back address is A+4+size.
- R9: On restore, a non-null header with an unrecognised size/format byte for the selected generation is treated as header-only, and `fmt_err_o` is 1 in the done cycle.
- R10: Mode 3 (register-direct) makes no memory request. The done pulse comes with `illegal_o`=1 and `wb_en_o`=0.
- R11: While a request waits for ready, the request, address, write enable and write data hold steady. Done is a single-cycle pulse, raised in the cycle after the final accepted transfer (or after the start, for an illegal mode). After reset, the engine is idle with no request and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when the engine is idle |
| op_restore_i | input | 1 | 0 = save, 1 = restore |
| mode_i | input | 2 | Addressing mode: 0 indirect, 1 postincrement, 2 predecrement, 3 register-direct |
| gen_i | input | 1 | Core generation: 0 older, 1 integrated |
| addr_i | input | 32 | Start address (address-register value) |
| mem_req_o | output | 1 | Memory request valid |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 32 | Word address of the request |
| mem_wdata_o | output | 32 | Write data |
| mem_ready_i | input | 1 | Memory accepts or answers the request this cycle |
| mem_rdata_i | input | 32 | Read data, valid with ready on a read |
| done_o | output | 1 | One-cycle completion pulse |
| illegal_o | output | 1 | Mode was register-direct (valid with done) |
| fmt_err_o | output | 1 | Unrecognised frame size byte (valid with done) |
| wb_en_o | output | 1 | Write back the address register (valid with done) |
| wb_addr_o | output | 32 | Updated address-register value (valid with done) |

## Verification
A memory transfer happens at the clock edge where request and ready are both high. The monitor samples request and ready just after ready is changed at the falling edge. It compares each transfer's direction, address and data against the next queued item at that sample point.

The done pulse with its flags and write-back address is due one cycle after the final accepted transfer. For a register-direct start, it is due one cycle after the start is taken. The monitor records the cycle of each transfer and each start, and checks that done arrives exactly one cycle later.

Ready is stalled in a fixed rotating pattern, so the hold behaviour is exercised on most frames.

// File: rtl/fctx_pkg.sv
package fctx_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 3;
  localparam int SZ_W   = 8;

  typedef enum logic [1:0] {
    AM_IND     = 2'd0,
    AM_POSTINC = 2'd1,
    AM_PREDEC  = 2'd2,
    AM_REGDIR  = 2'd3
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_DONE = 2'd2
  } fstate_e;

  localparam logic [WORD_W-1:0] OLD_HEAD_WORD = 32'h1F18_0000;
  localparam logic [WORD_W-1:0] OLD_TAIL_WORD = 32'h7000_0000;
  localparam logic [WORD_W-1:0] INT_IDLE_WORD = 32'h4100_0000;
  localparam int OLD_SAVE_WORDS = 7;
  localparam int INT_SAVE_WORDS = 1;

  function automatic logic [IDX_W:0] save_len(input logic gen);
    return gen ? (IDX_W+1)'(INT_SAVE_WORDS) : (IDX_W+1)'(OLD_SAVE_WORDS);
  endfunction
endpackage

// File: rtl/fctx_save_words.sv
module fctx_save_words
  import fctx_pkg::*;
(
  input  logic              gen_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] word_o
);
  localparam logic [IDX_W-1:0] LAST_OLD = IDX_W'(OLD_SAVE_WORDS - 1);

  always_comb begin
    if (gen_i) begin
      word_o = INT_IDLE_WORD;
    end else if (idx_i == '0) begin
      word_o = OLD_HEAD_WORD;
    end else if (idx_i == LAST_OLD) begin
      word_o = OLD_TAIL_WORD;
    end else begin
      word_o = '0;
    end
  end
endmodule

// File: rtl/fctx_hdr_decode.sv
module fctx_hdr_decode
  import fctx_pkg::*;
(
  input  logic              gen_i,
  input  logic [WORD_W-1:0] hdr_i,
  output logic [SZ_W-1:0]   extra_bytes_o,
  output logic              bad_fmt_o
);
  logic [7:0] ver_byte;
  logic [7:0] sz_byte;

  assign ver_byte = hdr_i[31:24];
  assign sz_byte  = hdr_i[23:16];

  always_comb begin
    extra_bytes_o = '0;
    bad_fmt_o     = 1'b0;
    if (ver_byte != 8'h00) begin
      if (!gen_i) begin
        unique case (sz_byte)
          8'h18:   extra_bytes_o = SZ_W'(6 * 4);
          8'h38:   extra_bytes_o = SZ_W'(14 * 4);
          8'hB4:   extra_bytes_o = SZ_W'(45 * 4);
          default: bad_fmt_o = 1'b1;
        endcase
      end else begin
        unique case (sz_byte)
          8'h00:   extra_bytes_o = '0;
          8'h30:   extra_bytes_o = SZ_W'(44);
          8'h60:   extra_bytes_o = SZ_W'(92);
          default: bad_fmt_o = 1'b1;
        endcase
      end
    end
  end
endmodule

// File: rtl/fpu_ctx_frame_engine.sv
module fpu_ctx_frame_engine
  import fctx_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_restore_i,
  input  logic [1:0]        mode_i,
  input  logic              gen_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ready_i,
  input  logic [31:0]       mem_rdata_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic              fmt_err_o,
  output logic              wb_en_o,
  output logic [ADDR_W-1:0] wb_addr_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_W / 8);

  // reset synchroniser: asserts asynchronously, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  fstate_e          st_q, st_d;
  logic             op_q, op_d;
  amode_e           mode_q, mode_d;
  logic             gen_q, gen_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W:0]   rem_q, rem_d;
  logic             ill_q, ill_d;
  logic             fmt_q, fmt_d;
  logic [ADDR_W-1:0] wb_q, wb_d;
  logic             data_en;

  logic [WORD_W-1:0] save_word;
  logic [SZ_W-1:0]   extra_bytes;
  logic              bad_fmt;
  logic [ADDR_W-1:0] extra_ext;
  logic [IDX_W:0]    start_len;
  logic              start_pd;

  fctx_save_words u_words (
    .gen_i  (gen_q),
    .idx_i  (idx_q),
    .word_o (save_word)
  );

  fctx_hdr_decode u_hdr (
    .gen_i         (gen_q),
    .hdr_i         (mem_rdata_i),
    .extra_bytes_o (extra_bytes),
    .bad_fmt_o     (bad_fmt)
  );

  assign extra_ext = {{(ADDR_W-SZ_W){1'b0}}, extra_bytes};
  assign start_len = op_restore_i ? (IDX_W+1)'(1) : save_len(gen_i);
  assign start_pd  = (amode_e'(mode_i) == AM_PREDEC);

  always_comb begin
    st_d    = st_q;
    op_d    = op_q;
    mode_d  = mode_q;
    gen_d   = gen_q;
    addr_d  = addr_q;
    idx_d   = idx_q;
    rem_d   = rem_q;
    ill_d   = ill_q;
    fmt_d   = fmt_q;
    wb_d    = wb_q;
    data_en = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          data_en = 1'b1;
          op_d    = op_restore_i;
          mode_d  = amode_e'(mode_i);
          gen_d   = gen_i;
          fmt_d   = 1'b0;
          wb_d    = addr_i;
          rem_d   = start_len;
          addr_d  = start_pd ? addr_i - STEP : addr_i;
          idx_d   = start_pd ? IDX_W'(start_len - 1'b1) : '0;
          if (amode_e'(mode_i) == AM_REGDIR) begin
            ill_d = 1'b1;
            st_d  = ST_DONE;
          end else begin
            ill_d = 1'b0;
            st_d  = ST_XFER;
          end
        end
      end
      ST_XFER: begin
        if (mem_ready_i) begin
          data_en = 1'b1;
          if (op_q) begin
            fmt_d = bad_fmt;
            wb_d  = (mode_q == AM_PREDEC) ? addr_q - extra_ext
                                          : addr_q + STEP + extra_ext;
            st_d  = ST_DONE;
          end else if (rem_q == (IDX_W+1)'(1)) begin
            wb_d = (mode_q == AM_PREDEC) ? addr_q : addr_q + STEP;
            st_d = ST_DONE;
          end else begin
            rem_d = rem_q - 1'b1;
            if (mode_q == AM_PREDEC) begin
              addr_d = addr_q - STEP;
              idx_d  = idx_q - 1'b1;
            end else begin
              addr_d = addr_q + STEP;
              idx_d  = idx_q + 1'b1;
            end
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) st_q <= ST_IDLE;
    else            st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      op_q   <= 1'b0;
      mode_q <= AM_IND;
      gen_q  <= 1'b0;
      addr_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      ill_q  <= 1'b0;
      fmt_q  <= 1'b0;
      wb_q   <= '0;
    end else if (data_en) begin
      op_q   <= op_d;
      mode_q <= mode_d;
      gen_q  <= gen_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      ill_q  <= ill_d;
      fmt_q  <= fmt_d;
      wb_q   <= wb_d;
    end
  end

  assign mem_req_o   = (st_q == ST_XFER);
  assign mem_we_o    = (st_q == ST_XFER) && !op_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = save_word;
  assign done_o      = (st_q == ST_DONE);
  assign illegal_o   = done_o && ill_q;
  assign fmt_err_o   = done_o && fmt_q;
  assign wb_en_o     = done_o && !ill_q &&
                       (mode_q == AM_POSTINC || mode_q == AM_PREDEC);
  assign wb_addr_o   = wb_q;
endmodule

// File: rtl/fpu_ctx_frame_engine_chk.sv
module fpu_ctx_frame_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [31:0]       mem_wdata_o,
  input logic              mem_ready_i,
  input logic              done_o,
  input logic              illegal_o,
  input logic              fmt_err_o,
  input logic              wb_en_o
);
  p_hold_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_ready_i) |=> (mem_req_o && $stable(mem_addr_o) &&
                                     $stable(mem_we_o) && $stable(mem_wdata_o)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_no_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !mem_req_o);

  p_illegal_no_wb_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> (!wb_en_o && !fmt_err_o));

  p_illegal_no_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && illegal_o) |-> !$past(mem_req_o));

  p_fmt_only_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_err_o) |-> (done_o && !$past(mem_we_o)));
endmodule

bind fpu_ctx_frame_engine fpu_ctx_frame_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mem_req_o   (mem_req_o),
  .mem_we_o    (mem_we_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wdata_o (mem_wdata_o),
  .mem_ready_i (mem_ready_i),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .fmt_err_o   (fmt_err_o),
  .wb_en_o     (wb_en_o)
);

// File: tb/fpu_ctx_frame_engine_tb_top.sv
`timescale 1ns/1ps
module fpu_ctx_frame_engine_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_restore_i = 1'b0;
  logic [1:0]  mode_i = 2'd0;
  logic        gen_i = 1'b0;
  logic [31:0] addr_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o, mem_wdata_o;
  logic        mem_ready_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic        done_o, illegal_o, fmt_err_o, wb_en_o;
  logic [31:0] wb_addr_o;

  always #4 clk = ~clk;

  fpu_ctx_frame_engine dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_restore_i(op_restore_i),
    .mode_i(mode_i), .gen_i(gen_i), .addr_i(addr_i),
    .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
    .mem_wdata_o(mem_wdata_o), .mem_ready_i(mem_ready_i), .mem_rdata_i(mem_rdata_i),
    .done_o(done_o), .illegal_o(illegal_o), .fmt_err_o(fmt_err_o),
    .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o)
  );

  typedef struct {
    bit          is_done;
    bit          we;
    logic [31:0] addr;
    logic [31:0] data;
    bit          ill;
    bit          fmt;
    bit          wben;
    string       req;
  } item_t;

  item_t exp_q[$];
  int    n_vec = 0;
  int    n_bad = 0;
  int    cyc = 0;
  int    last_evt = -100;
  bit    mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input string what);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s", req, what);
    end
  endtask

  // monitor: sets ready for the coming edge, then samples
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      mem_ready_i = (cyc % 4) != 1;
      #1;
      if (mon_on) begin
        if (start_i) last_evt = cyc;
        if (mem_req_o && mem_ready_i) begin
          if (exp_q.size() == 0 || exp_q[0].is_done) begin
            check(1'b0, "R11", $sformatf("unexpected access addr %h we %0d, expected none",
                  mem_addr_o, mem_we_o));
          end else begin
            item_t e;
            e = exp_q.pop_front();
            check(mem_we_o == e.we && mem_addr_o == e.addr && (!e.we || mem_wdata_o == e.data),
                  e.req, $sformatf("access we=%0d addr=%h data=%h, expected we=%0d addr=%h data=%h",
                  mem_we_o, mem_addr_o, mem_wdata_o, e.we, e.addr, e.data));
          end
          last_evt = cyc;
        end
        if (done_o) begin
          if (exp_q.size() == 0 || !exp_q[0].is_done) begin
            check(1'b0, "R11", $sformatf("early done, %0d items pending, expected none",
                  exp_q.size()));
          end else begin
            item_t e;
            e = exp_q.pop_front();
            check(illegal_o == e.ill && fmt_err_o == e.fmt && wb_en_o == e.wben &&
                  (!e.wben || wb_addr_o == e.addr), e.req,
                  $sformatf("done ill=%0d fmt=%0d wben=%0d wb=%h, expected ill=%0d fmt=%0d wben=%0d wb=%h",
                  illegal_o, fmt_err_o, wb_en_o, wb_addr_o, e.ill, e.fmt, e.wben, e.addr));
            check(cyc - last_evt == 1, "R11",
                  $sformatf("done gap %0d cycles, expected 1", cyc - last_evt));
          end
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    n_vec++; n_bad++;
    $display("FAIL watchdog: run hung, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  function automatic logic [31:0] frame_word(bit gen, int i);
    if (gen) return 32'h4100_0000;
    if (i == 0) return 32'h1F18_0000;
    if (i == 6) return 32'h7000_0000;
    return 32'h0;
  endfunction

  task automatic push_acc(bit we, logic [31:0] a, logic [31:0] d, string req);
    item_t it;
    it.is_done = 0; it.we = we; it.addr = a; it.data = d;
    it.ill = 0; it.fmt = 0; it.wben = 0; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic push_done(bit ill, bit fmt, bit wben, logic [31:0] a, string req);
    item_t it;
    it.is_done = 1; it.we = 0; it.addr = a; it.data = 0;
    it.ill = ill; it.fmt = fmt; it.wben = wben; it.req = req;
    exp_q.push_back(it);
  endtask

  task automatic run_op(bit rest, logic [1:0] mode, bit gen, logic [31:0] a,
                        logic [31:0] hdr, string req);
    int n;
    int sz;
    bit bad;
    logic [31:0] fin;
    if (mode == 2'd3) begin
      push_done(1, 0, 0, 32'h0, req);
    end else if (!rest) begin
      n = gen ? 1 : 7;
      if (mode == 2'd2) begin
        for (int j = 0; j < n; j++) push_acc(1, a - 32'(4*(j+1)), frame_word(gen, n-1-j), req);
        fin = a - 32'(4*n);
      end else begin
        for (int j = 0; j < n; j++) push_acc(1, a + 32'(4*j), frame_word(gen, j), req);
        fin = a + 32'(4*n);
      end
      push_done(0, 0, mode != 2'd0, fin, req);
    end else begin
      sz = 0; bad = 0;
      if (hdr[31:24] != 0) begin
        if (!gen) begin
          if (hdr[23:16] == 8'h18) sz = 24;
          else if (hdr[23:16] == 8'h38) sz = 56;
          else if (hdr[23:16] == 8'hB4) sz = 180;
          else bad = 1;
        end else begin
          if (hdr[23:16] == 8'h00) sz = 0;
          else if (hdr[23:16] == 8'h30) sz = 44;
          else if (hdr[23:16] == 8'h60) sz = 92;
          else bad = 1;
        end
      end
      if (mode == 2'd2) begin
        push_acc(0, a - 4, 0, req);
        fin = a - 4 - 32'(sz);
      end else begin
        push_acc(0, a, 0, req);
        fin = a + 4 + 32'(sz);
      end
      push_done(0, bad, mode != 2'd0, fin, req);
    end
    @(negedge clk);
    op_restore_i = rest; mode_i = mode; gen_i = gen; addr_i = a;
    mem_rdata_i = hdr; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    wait (exp_q.size() == 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    check(!mem_req_o && !done_o, "R11",
          $sformatf("reset req=%0d done=%0d, expected 0 0", mem_req_o, done_o));
    mon_on = 1'b1;

    run_op(0, 2'd1, 0, 32'h0000_1000, 0, "R1");
    run_op(0, 2'd1, 1, 32'h0000_2000, 0, "R2");
    run_op(0, 2'd2, 0, 32'h0000_3000, 0, "R3");
    run_op(0, 2'd2, 1, 32'h0000_3100, 0, "R3");
    run_op(0, 2'd0, 0, 32'h0000_4000, 0, "R4");
    run_op(1, 2'd0, 1, 32'h0000_4100, 32'h4130_0000, "R4");
    run_op(1, 2'd1, 0, 32'h0000_5000, 32'h1F18_0000, "R6");
    run_op(1, 2'd2, 0, 32'h0000_5200, 32'h1F38_0000, "R8");
    run_op(1, 2'd1, 0, 32'h0000_5400, 32'h1FB4_0000, "R6");
    run_op(1, 2'd2, 1, 32'h0000_6000, 32'h4100_0000, "R7");
    run_op(1, 2'd1, 1, 32'h0000_6100, 32'h4130_0000, "R7");
    run_op(1, 2'd2, 1, 32'h0000_6200, 32'h4160_0000, "R8");
    run_op(1, 2'd1, 0, 32'h0000_7000, 32'h00B4_0000, "R5");
    run_op(1, 2'd2, 1, 32'h0000_7100, 32'h0030_0000, "R5");
    run_op(1, 2'd1, 0, 32'h0000_8000, 32'h1F20_0000, "R9");
    run_op(1, 2'd2, 1, 32'h0000_8100, 32'h4118_0000, "R9");
    run_op(0, 2'd3, 0, 32'h0000_9000, 0, "R10");
    run_op(1, 2'd3, 1, 32'h0000_9100, 32'h1F18_0000, "R10");
    run_op(0, 2'd1, 0, 32'hFFFF_FFE4, 0, "R1");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule